// File: doc/BRIEF.md
# Overlapping Register Window File

This block is the integer register file of a load/store processor core. Every instruction names registers through 5-bit architectural indices, and the block maps each index onto a larger physical store through a current window pointer. Indices 0 to 7 name shared global registers. The other 24 indices name the registers of the active window: 8 incoming-parameter registers, 8 locals and 8 outgoing-parameter registers. Neighbouring windows overlap. The outgoing group of one window is the same storage as the incoming group of the next window. A caller therefore places arguments in its outgoing registers, and the callee finds them in its incoming registers with no copy and no memory traffic.

The block has two combinational read ports and one write port. A call strobe moves the pointer forward by one window, and a return strobe moves it back. A count of resident windows guards both moves. A call that would need more windows than the store holds raises an overflow flag, and a return from the last resident window raises an underflow flag. In both cases the pointer does not move, so software can spill or fill the windows through a memory stack and then retry.

Top module: `rwin_regfile`

## Requirements
- R1: After reset, the window pointer `cwp_o` is 0, both flags are low, one window is resident, and every one of the 32 architectural registers reads 0.
- R2: Indices 0 to 7 address the same storage from every window. A value written to one of them in any window reads back unchanged in every other window.
- R3: Indices 16 to 23 are private to each window. A write to them in one window changes no local register of any other window.
- R4: Index 24+n in window k and index 8+n in window k+1 (modulo 8, with n from 0 to 7) are the same register. A value written by the caller is read by the callee, and a value written by the callee is seen again by the caller after the return.
- R5: A call strobe (`call_i` high, `ret_i` low) accepted at a clock edge sets `cwp_o` to (cwp_o + 1) mod 8 and adds one resident window.
- R6: A return strobe (`ret_i` high, `call_i` low) accepted at a clock edge sets `cwp_o` to (cwp_o - 1) mod 8 and removes one resident window.
- R7: A call made while 7 windows are resident drives `overflow_o` high in that same cycle. At the next edge, `cwp_o` and the resident count stay unchanged.
- R8: A return made while only 1 window is resident drives `underflow_o` high in that same cycle. At the next edge, `cwp_o` and the resident count stay unchanged.
- R9: When `call_i` and `ret_i` are both high, the strobes are ignored. Neither flag rises, and `cwp_o` does not change.
- R10: When a write in one cycle targets the same architectural index that a read port presents, that port returns the write data in the same cycle.
- R11: A write, and the reads, in a cycle that also carries a call or return use the window that is current before the move.
- R12: A write is committed at the clock edge and is readable from the next cycle onward.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| rd_a_idx | input | 5 | Architectural index for read port A |
| rd_a_data | output | 32 | Read data for port A, combinational |
| rd_b_idx | input | 5 | Architectural index for read port B |
| rd_b_data | output | 32 | Read data for port B, combinational |
| wr_en | input | 1 | Write enable |
| wr_idx | input | 5 | Architectural index for the write |
| wr_data | input | 32 | Write data |
| call_i | input | 1 | Advance to the next window |
| ret_i | input | 1 | Go back to the previous window |
| overflow_o | output | 1 | Call refused because all usable windows are resident |
| underflow_o | output | 1 | Return refused because only one window is resident |
| cwp_o | output | 3 | Current window pointer |

## Verification
The critical overlap is a register write in the same cycle as a call or a return. The write must land in the window that is current before the move, while the pointer changes at that same edge. The bench provokes this by writing locals and outgoing registers together with call strobes, and also when the strobe is refused by overflow or underflow. It then reads those registers from both the new window and the old window. A reference model that keeps per-window register groups judges every cycle. The model also predicts same-cycle forwarding when the written index equals a read index.

// File: rtl/rwf_pkg.sv
package rwf_pkg;
  localparam int ARCH_N  = 32;
  localparam int IDX_W   = $clog2(ARCH_N);
  localparam int GRP_N   = 8;
  localparam int OFF_W   = $clog2(GRP_N);
  localparam int SLOT_N  = 2 * GRP_N;
  localparam int SLOT_SH = $clog2(SLOT_N);

  typedef enum logic [1:0] {
    GRP_GLOBAL = 2'd0,
    GRP_IN     = 2'd1,
    GRP_LOCAL  = 2'd2,
    GRP_OUT    = 2'd3
  } reg_grp_e;
endpackage

// File: rtl/rwf_map.sv
module rwf_map
  import rwf_pkg::*;
#(
  parameter int NWIN   = 8,
  parameter int CWP_W  = $clog2(NWIN),
  parameter int PHYS_W = 8
) (
  input  logic [IDX_W-1:0]  arch_idx,
  input  logic [CWP_W-1:0]  cwp,
  output logic [PHYS_W-1:0] phys_idx
);
  logic [CWP_W-1:0]  prev_win;
  logic [PHYS_W-1:0] cur_base;
  logic [PHYS_W-1:0] prev_base;
  logic [PHYS_W-1:0] off;
  reg_grp_e          grp;

  always_comb begin
    prev_win  = (cwp == '0) ? CWP_W'(NWIN - 1) : cwp - CWP_W'(1);
    cur_base  = PHYS_W'(GRP_N) + (PHYS_W'(cwp) << SLOT_SH);
    prev_base = PHYS_W'(GRP_N) + (PHYS_W'(prev_win) << SLOT_SH);
    off       = PHYS_W'(arch_idx[OFF_W-1:0]);
    grp       = reg_grp_e'(arch_idx[IDX_W-1:OFF_W]);
    unique case (grp)
      GRP_GLOBAL: phys_idx = off;
      GRP_IN:     phys_idx = prev_base + PHYS_W'(GRP_N) + off;
      GRP_LOCAL:  phys_idx = cur_base + off;
      GRP_OUT:    phys_idx = cur_base + PHYS_W'(GRP_N) + off;
      default:    phys_idx = off;
    endcase
  end
endmodule

// File: rtl/rwf_ctrl.sv
module rwf_ctrl #(
  parameter int NWIN  = 8,
  parameter int CWP_W = $clog2(NWIN),
  parameter int CNT_W = $clog2(NWIN + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             call_i,
  input  logic             ret_i,
  output logic [CWP_W-1:0] cwp,
  output logic [CNT_W-1:0] win_cnt,
  output logic             overflow,
  output logic             underflow
);
  localparam logic [CNT_W-1:0] RES_MAX = CNT_W'(NWIN - 1);
  localparam logic [CNT_W-1:0] RES_MIN = CNT_W'(1);
  localparam logic [CWP_W-1:0] CWP_TOP = CWP_W'(NWIN - 1);

  logic [CWP_W-1:0] cwp_q, cwp_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             only_call, only_ret, full, last, do_call, do_ret, upd_en;

  always_comb begin
    only_call = call_i & ~ret_i;
    only_ret  = ret_i & ~call_i;
    full      = (cnt_q == RES_MAX);
    last      = (cnt_q == RES_MIN);
    do_call   = only_call & ~full;
    do_ret    = only_ret & ~last;
    upd_en    = do_call | do_ret;
    cwp_d     = cwp_q;
    cnt_d     = cnt_q;
    if (do_call) begin
      cwp_d = (cwp_q == CWP_TOP) ? '0 : cwp_q + CWP_W'(1);
      cnt_d = cnt_q + CNT_W'(1);
    end else if (do_ret) begin
      cwp_d = (cwp_q == '0) ? CWP_TOP : cwp_q - CWP_W'(1);
      cnt_d = cnt_q - CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cwp_q <= '0;
      cnt_q <= RES_MIN;
    end else if (upd_en) begin
      cwp_q <= cwp_d;
      cnt_q <= cnt_d;
    end
  end

  assign cwp       = cwp_q;
  assign win_cnt   = cnt_q;
  assign overflow  = only_call & full;
  assign underflow = only_ret & last;
endmodule

// File: rtl/rwf_array.sv
module rwf_array #(
  parameter int DATA_W = 32,
  parameter int PHYS_N = 136,
  parameter int PHYS_W = $clog2(PHYS_N)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [PHYS_W-1:0] wr_phys,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [PHYS_W-1:0] rd_a_phys,
  input  logic [PHYS_W-1:0] rd_b_phys,
  output logic [DATA_W-1:0] rd_a_data,
  output logic [DATA_W-1:0] rd_b_data
);
  logic [DATA_W-1:0] mem_q [PHYS_N];

  for (genvar e = 0; e < PHYS_N; e++) begin : g_ent
    logic ent_we;
    assign ent_we = wr_en & (wr_phys == PHYS_W'(e));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      mem_q[e] <= '0;
      else if (ent_we) mem_q[e] <= wr_data;
    end
  end

  logic hit_a, hit_b;
  always_comb begin
    hit_a     = wr_en & (wr_phys == rd_a_phys);
    hit_b     = wr_en & (wr_phys == rd_b_phys);
    rd_a_data = hit_a ? wr_data : mem_q[rd_a_phys];
    rd_b_data = hit_b ? wr_data : mem_q[rd_b_phys];
  end
endmodule

// File: rtl/rwin_regfile.sv
module rwin_regfile
  import rwf_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int NWIN   = 8,
  localparam int CWP_W  = $clog2(NWIN),
  localparam int CNT_W  = $clog2(NWIN + 1),
  localparam int PHYS_N = GRP_N + NWIN * SLOT_N,
  localparam int PHYS_W = $clog2(PHYS_N)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [4:0]        rd_a_idx,
  output logic [DATA_W-1:0] rd_a_data,
  input  logic [4:0]        rd_b_idx,
  output logic [DATA_W-1:0] rd_b_data,
  input  logic              wr_en,
  input  logic [4:0]        wr_idx,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              call_i,
  input  logic              ret_i,
  output logic              overflow_o,
  output logic              underflow_o,
  output logic [CWP_W-1:0]  cwp_o
);
  logic             rst_meta_q, rst_sync_n;
  logic [CWP_W-1:0] cwp;
  logic [CNT_W-1:0] win_cnt;
  logic [PHYS_W-1:0] wr_phys, rd_a_phys, rd_b_phys;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_n <= rst_meta_q;
    end
  end

  rwf_ctrl #(.NWIN(NWIN), .CWP_W(CWP_W), .CNT_W(CNT_W)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .call_i    (call_i),
    .ret_i     (ret_i),
    .cwp       (cwp),
    .win_cnt   (win_cnt),
    .overflow  (overflow_o),
    .underflow (underflow_o)
  );

  rwf_map #(.NWIN(NWIN), .CWP_W(CWP_W), .PHYS_W(PHYS_W)) u_map_wr (
    .arch_idx (wr_idx), .cwp (cwp), .phys_idx (wr_phys)
  );
  rwf_map #(.NWIN(NWIN), .CWP_W(CWP_W), .PHYS_W(PHYS_W)) u_map_ra (
    .arch_idx (rd_a_idx), .cwp (cwp), .phys_idx (rd_a_phys)
  );
  rwf_map #(.NWIN(NWIN), .CWP_W(CWP_W), .PHYS_W(PHYS_W)) u_map_rb (
    .arch_idx (rd_b_idx), .cwp (cwp), .phys_idx (rd_b_phys)
  );

  rwf_array #(.DATA_W(DATA_W), .PHYS_N(PHYS_N), .PHYS_W(PHYS_W)) u_array (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .wr_en     (wr_en),
    .wr_phys   (wr_phys),
    .wr_data   (wr_data),
    .rd_a_phys (rd_a_phys),
    .rd_b_phys (rd_b_phys),
    .rd_a_data (rd_a_data),
    .rd_b_data (rd_b_data)
  );

  assign cwp_o = cwp;
endmodule

// File: rtl/rwin_regfile_chk.sv
module rwin_regfile_chk #(
  parameter int DATA_W = 32,
  parameter int CWP_W  = 3,
  parameter int CNT_W  = 4,
  parameter int NWIN   = 8
) (
  input logic              clk,
  input logic              rst_sync_n,
  input logic              call_i,
  input logic              ret_i,
  input logic              overflow_o,
  input logic              underflow_o,
  input logic [CWP_W-1:0]  cwp_o,
  input logic [CNT_W-1:0]  win_cnt,
  input logic              wr_en,
  input logic [4:0]        wr_idx,
  input logic [4:0]        rd_a_idx,
  input logic [4:0]        rd_b_idx,
  input logic [DATA_W-1:0] wr_data,
  input logic [DATA_W-1:0] rd_a_data,
  input logic [DATA_W-1:0] rd_b_data
);
  // R5
  call_step_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (call_i && !ret_i && !overflow_o) |=>
      (cwp_o == (($past(cwp_o) == CWP_W'(NWIN - 1)) ? '0 : $past(cwp_o) + CWP_W'(1))));
  // R6
  ret_step_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (ret_i && !call_i && !underflow_o) |=>
      (cwp_o == (($past(cwp_o) == '0) ? CWP_W'(NWIN - 1) : $past(cwp_o) - CWP_W'(1))));
  // R7
  overflow_hold_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    overflow_o |=> ($stable(cwp_o) && $stable(win_cnt)));
  // R8
  underflow_hold_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    underflow_o |=> ($stable(cwp_o) && $stable(win_cnt)));
  // R9
  both_strobe_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (call_i && ret_i) |=> $stable(cwp_o));
  // R9
  both_noflag_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (call_i && ret_i) |-> (!overflow_o && !underflow_o));
  // R7
  resident_range_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (win_cnt >= CNT_W'(1)) && (win_cnt <= CNT_W'(NWIN - 1)));
  // R10
  fwd_a_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (wr_en && wr_idx == rd_a_idx) |-> (rd_a_data == wr_data));
  // R10
  fwd_b_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (wr_en && wr_idx == rd_b_idx) |-> (rd_b_data == wr_data));
endmodule

bind rwin_regfile rwin_regfile_chk #(
  .DATA_W(DATA_W), .CWP_W(CWP_W), .CNT_W(CNT_W), .NWIN(NWIN)
) u_chk (
  .clk         (clk),
  .rst_sync_n  (rst_sync_n),
  .call_i      (call_i),
  .ret_i       (ret_i),
  .overflow_o  (overflow_o),
  .underflow_o (underflow_o),
  .cwp_o       (cwp_o),
  .win_cnt     (win_cnt),
  .wr_en       (wr_en),
  .wr_idx      (wr_idx),
  .rd_a_idx    (rd_a_idx),
  .rd_b_idx    (rd_b_idx),
  .wr_data     (wr_data),
  .rd_a_data   (rd_a_data),
  .rd_b_data   (rd_b_data)
);

// File: tb/rwin_regfile_tb.sv
module rwin_regfile_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [4:0]  rd_a_idx, rd_b_idx, wr_idx;
  logic [31:0] rd_a_data, rd_b_data, wr_data;
  logic        wr_en, call_i, ret_i, overflow_o, underflow_o;
  logic [2:0]  cwp_o;

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  // reference model: globals, and per-window locals / outgoing groups
  int unsigned m_glb [8];
  int unsigned m_loc [8][8];
  int unsigned m_out [8][8];
  int m_cwp;
  int m_res;

  always #5 clk = ~clk;

  rwin_regfile u_dut (
    .clk (clk), .rst_n (rst_n),
    .rd_a_idx (rd_a_idx), .rd_a_data (rd_a_data),
    .rd_b_idx (rd_b_idx), .rd_b_data (rd_b_data),
    .wr_en (wr_en), .wr_idx (wr_idx), .wr_data (wr_data),
    .call_i (call_i), .ret_i (ret_i),
    .overflow_o (overflow_o), .underflow_o (underflow_o), .cwp_o (cwp_o)
  );

  function automatic int unsigned m_read(int idx);
    if (idx < 8)       return m_glb[idx];
    else if (idx < 16) return m_out[(m_cwp + 7) % 8][idx - 8];
    else if (idx < 24) return m_loc[m_cwp][idx - 16];
    else               return m_out[m_cwp][idx - 24];
  endfunction

  task automatic m_write(int idx, int unsigned v);
    if (idx < 8)       m_glb[idx] = v;
    else if (idx < 16) m_out[(m_cwp + 7) % 8][idx - 8] = v;
    else if (idx < 24) m_loc[m_cwp][idx - 16] = v;
    else               m_out[m_cwp][idx - 24] = v;
  endtask

  task automatic check(string tag, longint act, longint exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic step(bit c, bit r, bit we, int wi, int unsigned wd,
                      int ra, int rb, string tag);
    int unsigned ea, eb;
    bit eo, eu;
    @(negedge clk);
    call_i = c; ret_i = r; wr_en = we;
    wr_idx = 5'(wi); wr_data = wd; rd_a_idx = 5'(ra); rd_b_idx = 5'(rb);
    #1;
    ea = (we && wi == ra) ? wd : m_read(ra);
    eb = (we && wi == rb) ? wd : m_read(rb);
    eo = c && !r && (m_res == 7);
    eu = r && !c && (m_res == 1);
    check({tag, " rd_a"}, rd_a_data, ea);
    check({tag, " rd_b"}, rd_b_data, eb);
    check({tag, " overflow"}, overflow_o, eo);
    check({tag, " underflow"}, underflow_o, eu);
    check({tag, " cwp"}, cwp_o, m_cwp);
    if (we) m_write(wi, wd);
    if (c && !r && !eo) begin m_cwp = (m_cwp + 1) % 8; m_res++; end
    if (r && !c && !eu) begin m_cwp = (m_cwp + 7) % 8; m_res--; end
  endtask

  task automatic idle_read(int ra, int rb, string tag);
    step(0, 0, 0, 0, 0, ra, rb, tag);
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin : main
    for (int i = 0; i < 8; i++) begin
      m_glb[i] = 0;
      for (int j = 0; j < 8; j++) begin m_loc[i][j] = 0; m_out[i][j] = 0; end
    end
    m_cwp = 0; m_res = 1;
    rst_n = 1'b0; call_i = 0; ret_i = 0; wr_en = 0;
    wr_idx = 0; wr_data = 0; rd_a_idx = 0; rd_b_idx = 0;
    repeat (4) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    repeat (3) @(posedge clk);

    // R1: reset state of all 32 registers, pointer and flags
    for (int k = 0; k < 16; k++) idle_read(k, k + 16, "R1 reset");

    // R8: return with one resident window, with a write riding along (R11)
    step(0, 1, 1, 17, 32'h0000_A017, 17, 9, "R8 underflow");
    idle_read(17, 9, "R8 after underflow");

    // R9: both strobes together are ignored
    step(1, 1, 1, 3, 32'h0000_0303, 3, 24, "R9 both strobes");
    idle_read(3, 24, "R9 after both");

    // R12 / R10: write then read back; same-cycle forwarding
    step(0, 0, 1, 24, 32'hC0DE_0024, 24, 25, "R10 forward");
    idle_read(24, 25, "R12 committed");

    // R4: caller fills outgoing registers, then calls
    for (int n = 0; n < 8; n++) step(0, 0, 1, 24 + n, 32'h1000_0000 + n, 0, 0, "R4 fill out");
    // R11: write a local in the call cycle; it lands in window 0
    step(1, 0, 1, 16, 32'hBEEF_0016, 16, 8, "R11 call with write");
    for (int n = 0; n < 8; n++) idle_read(8 + n, 16 + n, "R4 callee in / R3 fresh local");
    // callee writes incoming and locals, R2 globals
    step(0, 0, 1, 9, 32'h2222_0009, 9, 2, "R4 callee write in");
    step(0, 0, 1, 16, 32'h3333_0016, 16, 2, "R3 callee local");
    step(0, 0, 1, 2, 32'h4444_0002, 2, 16, "R2 global write");
    // R6: return; caller sees its outs updated, its local intact
    step(0, 1, 0, 0, 0, 25, 16, "R6 return");
    idle_read(25, 16, "R4 caller out / R3 local");
    idle_read(2, 24, "R2 global from caller");

    // R5 / R7: call up to the limit and beyond
    for (int d = 0; d < 6; d++) step(1, 0, 1, 16, 32'h5000_0000 + d, 16, 2, "R5 call depth");
    step(1, 0, 1, 20, 32'h6666_0020, 20, 8, "R7 overflow with write");
    idle_read(20, 8, "R7 after overflow");
    step(1, 0, 0, 0, 0, 2, 16, "R7 overflow again");
    for (int d = 0; d < 6; d++) step(0, 1, 0, 0, 0, 16, 2, "R6 unwind");
    step(0, 1, 0, 0, 0, 16, 24, "R8 underflow at bottom");

    // mixed traffic
    for (int t = 0; t < 3000; t++) begin
      int unsigned rv;
      bit c, r;
      rv = $urandom;
      c  = (rv[2:0] == 3'd0);
      r  = (rv[5:3] == 3'd0);
      step(c, r, rv[6], int'(rv[11:7]), $urandom, int'(rv[16:12]),
           rv[17] ? int'(rv[11:7]) : int'(rv[22:18]), "R2/R3/R4/R5/R6/R10 mixed");
    end

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule